// File: doc/BRIEF.md
# Ring packet sync-lock detector

This block sits beside the receive path of a serial motion-control ring. Each packet seen on the ring presents an 8-bit address: the upper nibble names a master station and the lower nibble names a slave node under that master. The detector compares every accepted address against a 24-bit configuration word. When a packet carries the configured sync slave number, it raises a one-cycle sync-lock pulse that keeps the local phase timing locked to the ring's synchronizing master. It also reports, for every packet, whether the packet targets one of this card's active local nodes.

Packets arrive on a valid/ready stream input. The detector never stalls, so `pkt_ready_o` is always high and a packet is accepted on every cycle in which `pkt_valid_i` is high. There is no back-pressure on the results either: they are plain registered outputs. Software-side setup writes the configuration word through a load-enable port. Two plain controls shape the sync match. One drops the master-number comparison. The other declares this card to be the ring's synchronizing master, and while it is high no sync pulse is produced.

Top module: `ring_sync_detect`

## Requirements
- R1: After reset the configuration word is all zeros (no node active, sync slave 0, master 0), and `sync_pulse_o`, `hit_valid_o` and `hit_active_o` are low.
- R2: When `cfg_load_i` is high at a clock edge, `cfg_data_i` is stored. Bits 15:0 are the per-node enables for slave nodes 0 to 15, bits 19:16 are the sync slave number, and bits 23:20 are this card's master number.
- R3: When master checking is off (`master_chk_off_i`=1) and `sync_master_i`=0, an accepted packet whose address bits 3:0 equal the sync slave number raises `sync_pulse_o` in the cycle after acceptance.
- R4: When master checking is on (`master_chk_off_i`=0), the pulse also requires address bits 7:4 to equal the configured master number. Otherwise there is no pulse.
- R5: While `sync_master_i`=1 at acceptance, no sync pulse is produced for that packet, whatever the address.
- R6: `sync_pulse_o` is high for exactly one cycle per matching packet and is low in every cycle that does not follow an accepted packet, including back-to-back packets where only the first one matches.
- R7: `hit_valid_o` is high in the cycle after each accepted packet. In that cycle `hit_active_o` is 1 exactly when address bits 7:4 equal the master number and the enable bit indexed by address bits 3:0 is set.
- R8: `pkt_ready_o` is always 1 outside reset, so no packet is ever refused.
- R9: A packet accepted in the same cycle as a configuration load is judged against the configuration held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load_i | input | 1 | Load the configuration word |
| cfg_data_i | input | 24 | Configuration word: enables[15:0], sync slave[19:16], master[23:20] |
| master_chk_off_i | input | 1 | 1 = the sync match ignores the master nibble |
| sync_master_i | input | 1 | 1 = this card is the synchronizing master; sync detection off |
| pkt_valid_i | input | 1 | Packet address valid |
| pkt_ready_o | output | 1 | Always 1; the detector accepts every packet |
| pkt_addr_i | input | 8 | Packet address: master[7:4], slave[3:0] |
| sync_pulse_o | output | 1 | One-cycle sync-lock pulse |
| hit_valid_o | output | 1 | A packet result is presented this cycle |
| hit_active_o | output | 1 | The packet targets an active local node |

## Verification
Every result of this block is due exactly one clock after the edge that accepts the packet. The sync pulse and the active flag both appear together with `hit_valid_o`, and a configuration load takes effect on the following packet. The driver sets inputs on the falling edge and pushes the expected pair into a queue at the same time. The monitor samples on each falling edge, so it sees the registered result of the packet driven one falling edge earlier and pops it in order. On cycles without a result it checks that the sync pulse is low.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int NODE_CNT = 16;
  localparam int NUM_W    = $clog2(NODE_CNT);
  localparam int ADDR_W   = 2 * NUM_W;
  localparam int CFG_W    = NODE_CNT + 2 * NUM_W;

  typedef struct packed {
    logic [NUM_W-1:0]    master_num;
    logic [NUM_W-1:0]    sync_slave;
    logic [NODE_CNT-1:0] node_en;
  } rsd_cfg_t;

  typedef struct packed {
    logic [NUM_W-1:0] master_part;
    logic [NUM_W-1:0] slave_part;
  } rsd_addr_t;
endpackage

// File: rtl/rsd_cfg_reg.sv
module rsd_cfg_reg
  import rsd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CFG_W-1:0] data_i,
  output rsd_cfg_t         cfg_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_o <= '0;
    else if (load_i) cfg_o <= rsd_cfg_t'(data_i);
  end
endmodule

// File: rtl/rsd_node_decode.sv
module rsd_node_decode
  import rsd_pkg::*;
(
  input  rsd_cfg_t  cfg_i,
  input  rsd_addr_t addr_i,
  output logic      active_o
);
  logic [NODE_CNT-1:0] sel;

  for (genvar n = 0; n < NODE_CNT; n++) begin : g_node
    assign sel[n] = cfg_i.node_en[n] && (addr_i.slave_part == NUM_W'(n));
  end

  assign active_o = (addr_i.master_part == cfg_i.master_num) && (|sel);
endmodule

// File: rtl/rsd_sync_match.sv
module rsd_sync_match
  import rsd_pkg::*;
(
  input  rsd_cfg_t  cfg_i,
  input  rsd_addr_t addr_i,
  input  logic      chk_off_i,
  input  logic      is_sync_master_i,
  output logic      match_o
);
  logic slave_eq, master_ok;

  always_comb begin
    slave_eq  = (addr_i.slave_part == cfg_i.sync_slave);
    master_ok = chk_off_i || (addr_i.master_part == cfg_i.master_num);
    match_o   = !is_sync_master_i && slave_eq && master_ok;
  end
endmodule

// File: rtl/ring_sync_detect.sv
module ring_sync_detect
  import rsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic              master_chk_off_i,
  input  logic              sync_master_i,
  input  logic              pkt_valid_i,
  output logic              pkt_ready_o,
  input  logic [ADDR_W-1:0] pkt_addr_i,
  output logic              sync_pulse_o,
  output logic              hit_valid_o,
  output logic              hit_active_o
);
  rsd_cfg_t  cfg_q;
  rsd_addr_t addr;
  logic      sync_hit, node_hit, accept;

  assign addr        = rsd_addr_t'(pkt_addr_i);
  assign pkt_ready_o = 1'b1;
  assign accept      = pkt_valid_i && pkt_ready_o;

  rsd_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cfg_load_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg_q)
  );

  rsd_node_decode u_node (
    .cfg_i    (cfg_q),
    .addr_i   (addr),
    .active_o (node_hit)
  );

  rsd_sync_match u_sync (
    .cfg_i            (cfg_q),
    .addr_i           (addr),
    .chk_off_i        (master_chk_off_i),
    .is_sync_master_i (sync_master_i),
    .match_o          (sync_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_pulse_o <= 1'b0;
      hit_valid_o  <= 1'b0;
      hit_active_o <= 1'b0;
    end else begin
      sync_pulse_o <= accept && sync_hit;
      hit_valid_o  <= accept;
      hit_active_o <= accept && node_hit;
    end
  end
endmodule

// File: rtl/ring_sync_detect_chk.sv
module ring_sync_detect_chk
  import rsd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load_i,
  input logic [CFG_W-1:0]  cfg_data_i,
  input logic              master_chk_off_i,
  input logic              sync_master_i,
  input logic              pkt_valid_i,
  input logic [ADDR_W-1:0] pkt_addr_i,
  input logic              sync_pulse_o,
  input logic              hit_valid_o,
  input logic              hit_active_o
);
  rsd_cfg_t sh;

  always_ff @(posedge clk) begin
    if (!rst_n)          sh <= '0;
    else if (cfg_load_i) sh <= rsd_cfg_t'(cfg_data_i);
  end

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid_i |=> !sync_pulse_o); // R6
  AST_PULSE_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse_o |-> hit_valid_o); // R6
  AST_SYNC_MASTER_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_i && sync_master_i) |=> !sync_pulse_o); // R5
  AST_SLAVE_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_i && !sync_master_i && master_chk_off_i &&
     pkt_addr_i[NUM_W-1:0] == sh.sync_slave) |=> sync_pulse_o); // R3
  AST_MASTER_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_i && !master_chk_off_i &&
     pkt_addr_i[ADDR_W-1:NUM_W] != sh.master_num) |=> !sync_pulse_o); // R4
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_i |=> hit_valid_o); // R7
  AST_ACTIVE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_active_o |-> hit_valid_o); // R7
  AST_FOREIGN_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_i && pkt_addr_i[ADDR_W-1:NUM_W] != sh.master_num) |=> !hit_active_o); // R7
endmodule

bind ring_sync_detect ring_sync_detect_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_load_i       (cfg_load_i),
  .cfg_data_i       (cfg_data_i),
  .master_chk_off_i (master_chk_off_i),
  .sync_master_i    (sync_master_i),
  .pkt_valid_i      (pkt_valid_i),
  .pkt_addr_i       (pkt_addr_i),
  .sync_pulse_o     (sync_pulse_o),
  .hit_valid_o      (hit_valid_o),
  .hit_active_o     (hit_active_o)
);

// File: tb/test_ring_sync_detect.sv
module test_ring_sync_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load_i = 1'b0;
  logic [23:0] cfg_data_i = '0;
  logic        master_chk_off_i = 1'b0;
  logic        sync_master_i = 1'b0;
  logic        pkt_valid_i = 1'b0;
  logic        pkt_ready_o;
  logic [7:0]  pkt_addr_i = '0;
  logic        sync_pulse_o, hit_valid_o, hit_active_o;

  int checks = 0;
  int fails = 0;
  logic [23:0] model_cfg = '0;
  logic [1:0]  exp_q[$];
  string       tag_q[$];
  bit          running = 1'b0;

  always #2 clk = ~clk;

  ring_sync_detect i_ring_sync_detect (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] predict(logic [23:0] c, logic [7:0] a, logic off, logic sm);
    logic s, act;
    s   = !sm && (a[3:0] == c[19:16]) && (off || a[7:4] == c[23:20]);
    act = (a[7:4] == c[23:20]) && c[a[3:0]];
    return {s, act};
  endfunction

  // driver: called on a falling edge, returns on the next one
  task automatic send(string req, logic [7:0] a, logic off, logic sm,
                      logic ld = 1'b0, logic [23:0] nc = '0);
    pkt_valid_i = 1'b1; pkt_addr_i = a; master_chk_off_i = off; sync_master_i = sm;
    cfg_load_i = ld; cfg_data_i = nc;
    exp_q.push_back(predict(model_cfg, a, off, sm));
    tag_q.push_back(req);
    if (ld) model_cfg = nc;
    @(negedge clk);
    pkt_valid_i = 1'b0; cfg_load_i = 1'b0;
  endtask

  task automatic load(logic [23:0] c);
    cfg_load_i = 1'b1; cfg_data_i = c; model_cfg = c;
    @(negedge clk);
    cfg_load_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      check("R8 ready", {7'd0, pkt_ready_o}, 8'd1);
      if (hit_valid_o) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected result", 8'd1, 8'd0);
        end else begin
          logic [1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " sync"}, {7'd0, sync_pulse_o}, {7'd0, e[1]});
          check({t, " active"}, {7'd0, hit_active_o}, {7'd0, e[0]});
        end
      end else begin
        check("R6 idle pulse", {7'd0, sync_pulse_o}, 8'd0);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset sync", {7'd0, sync_pulse_o}, 8'd0);
        check("R1 reset valid", {7'd0, hit_valid_o}, 8'd0);
        check("R1 reset active", {7'd0, hit_active_o}, 8'd0);
        running = 1'b1;
        @(negedge clk);
        send("R1 default cfg", 8'h00, 1'b0, 1'b0);
        send("R1 default cfg node1", 8'h01, 1'b1, 1'b0);
        load(24'h00003F);
        send("R2 R7 node3", 8'h03, 1'b0, 1'b0);
        send("R7 node6 off", 8'h06, 1'b0, 1'b0);
        send("R4 node0 sync", 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        load(24'h1F1555);
        send("R4 master match", 8'h1F, 1'b0, 1'b0);
        send("R4 master mismatch", 8'h2F, 1'b0, 1'b0);
        send("R3 slave only", 8'h2F, 1'b1, 1'b0);
        send("R6 back-to-back", 8'h14, 1'b1, 1'b0);
        send("R7 odd node", 8'h15, 1'b0, 1'b0);
        send("R5 sync master", 8'h1F, 1'b1, 1'b1);
        send("R5 sync master chk", 8'h1F, 1'b0, 1'b1);
        send("R7 foreign master", 8'h0C, 1'b0, 1'b0);
        send("R9 old cfg", 8'h1F, 1'b1, 1'b0, 1'b1, 24'h2A0010);
        send("R9 new cfg node4", 8'h24, 1'b0, 1'b0);
        send("R9 new cfg sync", 8'h2A, 1'b0, 1'b0);
        send("R3 other master", 8'h7A, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        check("R7 queue drained", 8'(exp_q.size()), 8'd0);
      end
      begin
        repeat (5000) @(negedge clk);
        check("watchdog expired", 8'd1, 8'd0);
      end
    join_any
    running = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule